// File: doc/BRIEF.md
# Rollover-Counting Time-Window Readout Scanner

This block reads back a buffer of digitized records, one per address, after capture. Each record carries a 16-bit time word from a free-running counter that wraps to zero after full scale. A single 16-bit value cannot say how many counter periods have passed. The scanner rebuilds elapsed time by counting wraps as it walks the buffer. It forwards only the records that fall inside a requested window. The window is given as a whole number of counter periods plus a tick offset into the last period.

Wraps can be found in two ways, chosen at start. In marker mode, a record whose time word is all ones counts as a wrap. In difference mode, a record whose time word is lower than the previous one counts as a wrap. Difference mode still works when a marker record was corrupted at capture. Accepted records leave on a valid/ready stream, each with its elapsed time since the first reference record. A one-cycle done pulse ends every scan, and the wrap count stays readable until the next start.

Top module: `tw_readout_scanner`

## Requirements
- R1: A record is TIME_W time bits in its low bits with PAY_W payload bits above them. Records are read from `start_addr` upward, with the address wrapping modulo 2^ADDR_W. Accepted records leave unchanged and in address order.
- R2: In marker mode (`mode`=0), a record whose time word is all ones (65535) adds one to `roll_count`. It is forwarded when it is inside the window.
- R3: In difference mode (`mode`=1), a rollover is counted when a time word is lower than that of the previous non-marker record. All-ones records are not counted, not forwarded and not used as a reference.
- R4: In difference mode, the first non-marker record read after start becomes the reference, and no rollover is inferred on it.
- R5: A record is inside the window when the rollovers counted up to and including it are fewer than `win_periods`. It is also inside when that count equals `win_periods` and the record is either a marker in marker mode or has a time word no greater than `win_offset`. The first record outside the window ends the scan; it is neither forwarded nor counted, so `roll_count` never exceeds `win_periods`.
- R6: `rec_elapsed` = (rollovers before the record) × 2^TIME_W + time word − time word of the first reference record. In marker mode, a marker record's own rollover is not "before" it.
- R7: While `rec_valid` is high and `rec_ready` is low, the record and its elapsed time stay unchanged. No record is lost or repeated.
- R8: After the record at `last_addr` has been handled, the scan ends. `done` is high for exactly one cycle per scan, even when the window ends on that same record.
- R9: An accepted start clears `roll_count` in the next cycle. `roll_count` holds after done until the next start. A start pulse during a scan is ignored.
- R10: After reset, `rec_valid`, `done` and `mem_rd_en` are low and `roll_count` is zero.
- R11: Each record is fetched with exactly one single-cycle `mem_rd_en`, with data expected one cycle later. No read is issued while a record waits at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| mode | input | 1 | 0 marker mode, 1 difference mode |
| start_addr | input | ADDR_W | First address read |
| last_addr | input | ADDR_W | Last address read |
| win_periods | input | CNT_W | Whole counter periods in the window |
| win_offset | input | TIME_W | Time-word limit within the final period |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | TIME_W+PAY_W | Read data, one cycle after the strobe |
| rec_valid | output | 1 | Output record valid |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_data | output | TIME_W+PAY_W | Output record |
| rec_elapsed | output | CNT_W+TIME_W | Elapsed ticks since the reference record |
| done | output | 1 | One-cycle end-of-scan pulse |
| roll_count | output | CNT_W | Rollovers counted in the scan |

## Verification
Two end conditions can fall on the same record: the window boundary and the last-address limit. Both then arrive in the same evaluation cycle. The bench provokes this by placing a falling time word exactly at `last_addr` in difference mode. It then requires exactly one done pulse, no forwarding of that record, and an unchanged wrap count. A second overlap comes from a start pulse arriving mid-scan. It is judged by requiring the results of the scan already running.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_EV   = 3'd2,
    S_OUT  = 3'd3,
    S_FIN  = 3'd4
  } scan_st_e;

  typedef enum logic {
    M_MARK = 1'b0,
    M_DIFF = 1'b1
  } roll_mode_e;
endpackage

// File: rtl/tws_roll_track.sv
module tws_roll_track
  import tws_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 8,
  localparam int ELAP_W = CNT_W + TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  roll_mode_e        mode,
  input  logic [CNT_W-1:0]  win_periods,
  input  logic [TIME_W-1:0] win_offset,
  input  logic [TIME_W-1:0] tword,
  output logic              drop,
  output logic              stop,
  output logic [ELAP_W-1:0] elapsed,
  output logic [CNT_W-1:0]  cnt
);
  logic              first_q, first_d;
  logic [TIME_W-1:0] ref_q, ref_d;
  logic [TIME_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              trk_en;

  logic              is_mark;
  logic              wrap;
  logic [CNT_W:0]    cnt_ext;
  logic [CNT_W:0]    win_ext;
  logic [CNT_W-1:0]  el_cnt;
  logic [TIME_W-1:0] el_base;

  // record classification
  always_comb begin
    is_mark = &tword;
    drop    = (mode == M_DIFF) && is_mark;
    if (mode == M_MARK) begin
      wrap = is_mark;
    end else begin
      wrap = !is_mark && !first_q && (tword < ref_q);
    end
    cnt_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, wrap};
    win_ext = {1'b0, win_periods};
  end

  // window decision
  always_comb begin
    stop = 1'b0;
    if (!drop) begin
      if (cnt_ext > win_ext) begin
        stop = 1'b1;
      end else if ((cnt_ext == win_ext) && !((mode == M_MARK) && is_mark)
                   && (tword > win_offset)) begin
        stop = 1'b1;
      end
    end
  end

  // elapsed time: a marker closes its own period
  always_comb begin
    if ((mode == M_MARK) && is_mark) begin
      el_cnt = cnt_q;
    end else begin
      el_cnt = cnt_ext[CNT_W-1:0];
    end
    el_base = first_q ? tword : base_q;
    elapsed = {el_cnt, tword} - {{CNT_W{1'b0}}, el_base};
  end

  // next state
  always_comb begin
    first_d = first_q;
    ref_d   = ref_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    trk_en  = 1'b0;
    if (clr) begin
      trk_en  = 1'b1;
      first_d = 1'b1;
      ref_d   = '0;
      base_d  = '0;
      cnt_d   = '0;
    end else if (upd) begin
      trk_en = 1'b1;
      cnt_d  = cnt_ext[CNT_W-1:0];
      if (!drop) begin
        first_d = 1'b0;
        ref_d   = tword;
        if (first_q) begin
          base_d = tword;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      ref_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (trk_en) begin
      first_q <= first_d;
      ref_q   <= ref_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tws_scan_seq.sv
module tws_scan_seq
  import tws_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              stop,
  input  logic              drop,
  input  logic              rec_ready,
  output logic              clr,
  output logic              accept,
  output logic              load,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rec_valid,
  output logic              done,
  output logic              busy
);
  scan_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              addr_en, last_en;
  logic              at_last;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    last_d  = last_q;
    addr_en = 1'b0;
    last_en = 1'b0;
    clr     = 1'b0;
    accept  = 1'b0;
    load    = 1'b0;
    at_last = (addr_q == last_q);
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          clr     = 1'b1;
          addr_d  = start_addr;
          last_d  = last_addr;
          addr_en = 1'b1;
          last_en = 1'b1;
          st_d    = S_RD;
        end
      end
      S_RD: st_d = S_EV;
      S_EV: begin
        if (stop) begin
          st_d = S_FIN;
        end else begin
          accept = 1'b1;
          if (!drop) begin
            load = 1'b1;
            st_d = S_OUT;
          end else if (at_last) begin
            st_d = S_FIN;
          end else begin
            addr_d  = addr_q + 1'b1;
            addr_en = 1'b1;
            st_d    = S_RD;
          end
        end
      end
      S_OUT: begin
        if (rec_ready) begin
          if (at_last) begin
            st_d = S_FIN;
          end else begin
            addr_d  = addr_q + 1'b1;
            addr_en = 1'b1;
            st_d    = S_RD;
          end
        end
      end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  assign mem_rd_en = (st_q == S_RD);
  assign mem_addr  = addr_q;
  assign rec_valid = (st_q == S_OUT);
  assign done      = (st_q == S_FIN);
  assign busy      = (st_q != S_IDLE);
endmodule

// File: rtl/tws_rec_hold.sv
module tws_rec_hold #(
  parameter int REC_W  = 32,
  parameter int ELAP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REC_W-1:0]  rec_d,
  input  logic [ELAP_W-1:0] el_d,
  output logic [REC_W-1:0]  rec_q,
  output logic [ELAP_W-1:0] el_q
);
  logic [REC_W-1:0]  rec_r;
  logic [ELAP_W-1:0] el_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_r <= '0;
      el_r  <= '0;
    end else if (load) begin
      rec_r <= rec_d;
      el_r  <= el_d;
    end
  end

  assign rec_q = rec_r;
  assign el_q  = el_r;
endmodule

// File: rtl/tw_readout_scanner.sv
module tw_readout_scanner
  import tws_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int PAY_W  = 16,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  localparam int REC_W  = TIME_W + PAY_W,
  localparam int ELAP_W = CNT_W + TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [CNT_W-1:0]  win_periods,
  input  logic [TIME_W-1:0] win_offset,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [REC_W-1:0]  mem_rd_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [REC_W-1:0]  rec_data,
  output logic [ELAP_W-1:0] rec_elapsed,
  output logic              done,
  output logic [CNT_W-1:0]  roll_count
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // scan configuration, captured at an accepted start
  logic              clr, accept, load, busy;
  logic              stop, drop;
  roll_mode_e        mode_q;
  logic [CNT_W-1:0]  win_q;
  logic [TIME_W-1:0] off_q;
  logic [ELAP_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= M_MARK;
      win_q  <= '0;
      off_q  <= '0;
    end else if (clr) begin
      mode_q <= roll_mode_e'(mode);
      win_q  <= win_periods;
      off_q  <= win_offset;
    end
  end

  tws_scan_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_addr (start_addr),
    .last_addr  (last_addr),
    .stop       (stop),
    .drop       (drop),
    .rec_ready  (rec_ready),
    .clr        (clr),
    .accept     (accept),
    .load       (load),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .rec_valid  (rec_valid),
    .done       (done),
    .busy       (busy)
  );

  tws_roll_track #(.TIME_W(TIME_W), .CNT_W(CNT_W)) trk_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr         (clr),
    .upd         (accept),
    .mode        (mode_q),
    .win_periods (win_q),
    .win_offset  (off_q),
    .tword       (mem_rd_data[TIME_W-1:0]),
    .drop        (drop),
    .stop        (stop),
    .elapsed     (elapsed),
    .cnt         (roll_count)
  );

  tws_rec_hold #(.REC_W(REC_W), .ELAP_W(ELAP_W)) hold_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .rec_d (mem_rd_data),
    .el_d  (elapsed),
    .rec_q (rec_data),
    .el_q  (rec_elapsed)
  );
endmodule

// File: rtl/tw_readout_scanner_chk.sv
module tw_readout_scanner_chk #(
  parameter int TIME_W = 16,
  parameter int REC_W  = 32,
  parameter int ELAP_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [REC_W-1:0]  rec_data,
  input logic [ELAP_W-1:0] rec_elapsed,
  input logic              done,
  input logic              mem_rd_en,
  input logic [CNT_W-1:0]  roll_count,
  input logic [CNT_W-1:0]  win_q,
  input logic              mode_q,
  input logic              clr
);
  // R7: stalled output keeps its record
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_elapsed)));

  // R8: done lasts one cycle and never overlaps an offered record
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid);

  // R5: count bounded by the window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    roll_count <= win_q);

  // R2: count moves by at most one per record outside a start
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((roll_count == $past(roll_count)) || (roll_count == $past(roll_count) + 1'b1)));

  // R3: no all-ones record leaves in difference mode
  p_no_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && mode_q) |-> (rec_data[TIME_W-1:0] != {TIME_W{1'b1}}));

  // R11: no fetch while a record waits
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !mem_rd_en);

  // R11: read strobe is a single cycle
  p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind tw_readout_scanner tw_readout_scanner_chk #(
  .TIME_W (TIME_W),
  .REC_W  (REC_W),
  .ELAP_W (ELAP_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_valid   (rec_valid),
  .rec_ready   (rec_ready),
  .rec_data    (rec_data),
  .rec_elapsed (rec_elapsed),
  .done        (done),
  .mem_rd_en   (mem_rd_en),
  .roll_count  (roll_count),
  .win_q       (win_q),
  .mode_q      (mode_q),
  .clr         (clr)
);

// File: tb/tw_readout_scanner_tb_top.sv
`timescale 1ns/1ps
module tw_readout_scanner_tb_top;
  localparam int TW = 16;
  localparam int PW = 16;
  localparam int AW = 10;
  localparam int CW = 8;
  localparam int RW = TW + PW;
  localparam int EW = CW + TW;

  typedef struct packed {
    logic          mode;
    logic [AW-1:0] sa;
    logic [AW-1:0] la;
    logic [CW-1:0] win;
    logic [TW-1:0] off;
    logic          stall;
    logic [7:0]    n;
    logic [CW-1:0] rolls;
    logic [TW-1:0] t;
    logic [EW-1:0] el;
    logic [7:0]    reads;
  } scen_t;

  // mode sa la win off stall | n rolls last_t last_el reads
  // Memory time words: 0:100 1:30000 2:60000 3:FFFF 4:500 5:40000 6:FFFF 7:200
  // 8:9000 9:3000 10:7000 11:FFFF 12:100 13:50000 14:20000 15:FFFF 1023:65000
  // R4: entry 9 starts on a marker, so the record after it becomes the reference.
  localparam scen_t TAB [10] = '{
    '{1'b0, 10'd0,    10'd15, 8'd1, 16'd40000, 1'b0, 8'd6, 8'd1, 16'd40000, 24'd105436, 8'd7},
    '{1'b1, 10'd0,    10'd15, 8'd1, 16'd40000, 1'b1, 8'd5, 8'd1, 16'd40000, 24'd105436, 8'd8},
    '{1'b1, 10'd7,    10'd15, 8'd2, 16'd5000,  1'b0, 8'd5, 8'd2, 16'd100,   24'd130972, 8'd7},
    '{1'b0, 10'd7,    10'd15, 8'd2, 16'd5000,  1'b1, 8'd9, 8'd2, 16'd65535, 24'd130871, 8'd9},
    '{1'b1, 10'd13,   10'd15, 8'd0, 16'd60000, 1'b0, 8'd1, 8'd0, 16'd50000, 24'd0,      8'd2},
    '{1'b1, 10'd12,   10'd14, 8'd0, 16'd60000, 1'b0, 8'd2, 8'd0, 16'd50000, 24'd49900,  8'd3},
    '{1'b0, 10'd4,    10'd4,  8'd0, 16'd0,     1'b0, 8'd0, 8'd0, 16'd0,     24'd0,      8'd1},
    '{1'b0, 10'd4,    10'd4,  8'd0, 16'd1000,  1'b0, 8'd1, 8'd0, 16'd500,   24'd0,      8'd1},
    '{1'b1, 10'd1023, 10'd1,  8'd1, 16'd65535, 1'b1, 8'd3, 8'd1, 16'd30000, 24'd30536,  8'd3},
    '{1'b1, 10'd3,    10'd5,  8'd0, 16'd65535, 1'b0, 8'd2, 8'd0, 16'd40000, 24'd39500,  8'd3}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mode;
  logic [AW-1:0] start_addr, last_addr;
  logic [CW-1:0] win_periods;
  logic [TW-1:0] win_offset;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [RW-1:0] mem_rd_data;
  logic          rec_valid;
  logic          rec_ready;
  logic [RW-1:0] rec_data;
  logic [EW-1:0] rec_elapsed;
  logic          done;
  logic [CW-1:0] roll_count;

  logic [RW-1:0] mem [0:(1<<AW)-1];

  int  n_tests, n_fail;
  int  cyc;
  int  got_n, got_reads, got_done;
  logic [TW-1:0] got_t;
  logic [EW-1:0] got_el;
  logic stall_en;

  tw_readout_scanner #(.TIME_W(TW), .PAY_W(PW), .ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .start_addr  (start_addr),
    .last_addr   (last_addr),
    .win_periods (win_periods),
    .win_offset  (win_offset),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_data    (rec_data),
    .rec_elapsed (rec_elapsed),
    .done        (done),
    .roll_count  (roll_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // synchronous memory model
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
  end

  // stimulus of ready and monitor, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    rec_ready = stall_en ? ((cyc % 3) == 2) : 1'b1;
    if (rec_valid && rec_ready) begin
      got_n  = got_n + 1;
      got_t  = rec_data[TW-1:0];
      got_el = rec_elapsed;
    end
    if (mem_rd_en) got_reads = got_reads + 1;
    if (done) got_done = got_done + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input scen_t s, input bit poke, input string nm);
    string rtag;
    @(negedge clk);
    got_n = 0; got_reads = 0; got_done = 0; got_t = '0; got_el = '0;
    stall_en    = s.stall;
    mode        = s.mode;
    start_addr  = s.sa;
    last_addr   = s.la;
    win_periods = s.win;
    win_offset  = s.off;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(roll_count == 0, {nm, " R9 count cleared at start"}, roll_count, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; start_addr = 10'd7; mode = 1'b1; win_periods = 8'd0;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000 && got_done == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    rtag = s.mode ? "R3" : "R2";
    chk(got_done == 1, {nm, " R8 done pulses"}, got_done, 1);
    chk(got_n == int'(s.n), {nm, s.stall ? " R5/R7 records" : " R5 records"}, got_n, s.n);
    chk(roll_count == s.rolls, {nm, " ", rtag, " roll_count"}, roll_count, s.rolls);
    chk(got_reads == int'(s.reads), {nm, " R11 reads"}, got_reads, s.reads);
    if (s.n != 0) begin
      chk(got_t == s.t, {nm, " R1 last time word"}, got_t, s.t);
      chk(got_el == s.el, {nm, " R6 last elapsed"}, got_el, s.el);
    end
  endtask

  // watchdog
  initial begin
    wait (cyc >= 150000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0;
    got_n = 0; got_reads = 0; got_done = 0; got_t = '0; got_el = '0;
    stall_en = 1'b0; rec_ready = 1'b1;
    start = 1'b0; mode = 1'b0; start_addr = '0; last_addr = '0;
    win_periods = '0; win_offset = '0;
    for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
    begin
      logic [TW-1:0] tv [16];
      tv = '{16'd100, 16'd30000, 16'd60000, 16'hFFFF, 16'd500, 16'd40000, 16'hFFFF, 16'd200,
             16'd9000, 16'd3000, 16'd7000, 16'hFFFF, 16'd100, 16'd50000, 16'd20000, 16'hFFFF};
      for (int a = 0; a < 16; a++) mem[a] = {PW'(a), tv[a]};
      mem[(1 << AW) - 1] = {PW'(16'h3FF), 16'd65000};
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    chk(rec_valid == 1'b0, "R10 rec_valid in reset", rec_valid, 0);
    chk(done == 1'b0, "R10 done in reset", done, 0);
    chk(mem_rd_en == 1'b0, "R10 mem_rd_en in reset", mem_rd_en, 0);
    chk(roll_count == 0, "R10 roll_count in reset", roll_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rec_valid == 1'b0 && done == 1'b0, "R10 idle after release", {rec_valid, done}, 0);

    for (int k = 0; k < 10; k++) begin
      run(TAB[k], 1'b0, $sformatf("vec%0d", k));
    end

    // R9: a start pulse during a scan must not disturb it
    run(TAB[0], 1'b1, "busy_start");

    // R9: count holds after done until next start
    run(TAB[3], 1'b0, "hold_pre");
    repeat (20) @(negedge clk);
    chk(roll_count == 2, "R9 roll_count held after done", roll_count, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule